// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits between the board-level configuration straps of a clock generator and the logic that programs its synthesizers. The frequency-select straps, the output-function strap and the test-mode strap are captured once, at the moment the shared active-low power-good pin is first seen validly low. From then on they are held for the rest of operation. After that capture the same pin changes role: a high level on it becomes a real-time power-down request.

All pins pass through a two-flop synchronizer. A low counts as valid only when the synchronized level stays low for a configurable number of consecutive clocks, which is two by default. The held frequency straps are decoded into a two-bit CPU frequency code, and an invalid combination raises a flag. The output-function strap picks between two mutually exclusive output groups. In test mode the straps stay transparent, and the frequency-select B strap chooses between tri-stated outputs and the reference divided by N.

Top module: `pg_strap_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output returns to 0 (lock flag, held straps, code, flags, enables, power-down).
- R2: `locked` rises on the fourth rising edge after `pg_pd_pin` is driven low and held low. A low lasting only one clock never sets it.
- R3: On the locking edge, `fs_latched` takes `{fs_c, fs_b, fs_a}` (bit 2 = C, bit 0 = A) and `fsel_latched` takes `fsel`.
- R4: Outside test mode, once `locked` is 1, changes on the straps or on `pg_pd_pin` leave `fs_latched` and `fsel_latched` unchanged.
- R5: `locked` stays 1 until the next reset, whatever `pg_pd_pin` does.
- R6: `pwr_down` is 0 while unlocked. Once locked it follows a high `pg_pd_pin` two rising edges after the pin changes.
- R7: `cpu_freq` decodes `fs_latched` as 101 -> 0 (100 MHz), 001 -> 1 (133 MHz), 011 -> 2 (166 MHz), 010 -> 3 (200 MHz).
- R8: Any other `fs_latched` value gives `cpu_freq` = 0. When `locked` or test mode is active, it also sets `strap_invalid` = 1.
- R9: When locked and not in test mode, `fsel_latched` = 1 sets `en_dot96` (96 MHz dot + 100 MHz SRC) and `fsel_latched` = 0 sets `en_27m` (27 MHz pair + LCD clock). The two enables are never 1 together, and both are 0 otherwise.
- R10: With `test_mode` high, the held straps follow the pins three rising edges after a change, whether or not the block is locked.
- R11: In test mode, held FSB = 0 sets `test_tristate` and held FSB = 1 sets `test_refn`. Both are 0 outside test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_pd_pin | input | 1 | Power-good (active low) before lock, power-down (active high) after |
| fs_a | input | 1 | Frequency-select strap A |
| fs_b | input | 1 | Frequency-select strap B |
| fs_c | input | 1 | Frequency-select strap C |
| fsel | input | 1 | Output-function select strap |
| test_mode | input | 1 | Test-mode strap |
| locked | output | 1 | Configuration captured and frozen |
| fs_latched | output | 3 | Held straps {C,B,A} |
| fsel_latched | output | 1 | Held output-function strap |
| cpu_freq | output | 2 | Decoded CPU frequency code |
| strap_invalid | output | 1 | Held frequency straps form no defined code |
| en_dot96 | output | 1 | Enable 96 MHz dot and 100 MHz SRC group |
| en_27m | output | 1 | Enable 27 MHz pair and LCD clock group |
| pwr_down | output | 1 | Real-time power-down request |
| test_tristate | output | 1 | Test mode: outputs tri-stated |
| test_refn | output | 1 | Test mode: outputs drive reference / N |

## Verification
A wrong low-filter count or a lock flag that fails to stick shows within a few cycles. The symptom is `locked` rising one edge early or late, or dropping when the pin goes high, which would also drop `pwr_down`. If the freeze is lost, a strap change appears on `fs_latched` three edges later. That change then feeds through to `cpu_freq` and the group enables in the same cycle. A decode error appears at once on `cpu_freq` and `strap_invalid` for the affected strap pattern.

// File: rtl/pgsl_pkg.sv
// Package: shared types and strap patterns for the power-good strap latch.
// Assumes straps are packed {C,B,A} with A in bit 0.
package pgsl_pkg;
    typedef enum logic [1:0] {
        FREQ_100 = 2'd0,
        FREQ_133 = 2'd1,
        FREQ_166 = 2'd2,
        FREQ_200 = 2'd3
    } freq_code_e;

    localparam logic [2:0] PAT_100 = 3'b101;
    localparam logic [2:0] PAT_133 = 3'b001;
    localparam logic [2:0] PAT_166 = 3'b011;
    localparam logic [2:0] PAT_200 = 3'b010;
    localparam int         FS_W    = 3;
endpackage

// File: rtl/pgsl_sync.sv
// Module: multi-stage synchronizer for a bus of independent level inputs.
// Assumes each bit is a slow level; no bus coherency is implied.
module pgsl_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first sampling flop on the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pgsl_capture.sv
// Module: one-shot capture of straps on a filtered low of power-good.
// Assumes all inputs are already synchronized. The lock is sticky until reset.
// In test mode the strap registers reload every cycle.
module pgsl_capture #(
    parameter int VALID_CNT = 2,
    parameter int FS_W      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_s,
    input  logic            test_s,
    input  logic [FS_W-1:0] fs_s,
    input  logic            fsel_s,
    output logic            locked,
    output logic [FS_W-1:0] fs_q,
    output logic            fsel_q
);
    localparam int CNT_W = $clog2(VALID_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VALID_CNT - 1);

    logic [CNT_W-1:0] low_cnt;
    logic             lock_now;

    // Purpose: the edge on which a qualified low completes.
    assign lock_now = !locked && !pg_s && (low_cnt == CNT_LAST);

    // Purpose: count consecutive synchronized lows before lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (locked || pg_s)    low_cnt <= '0;
        else if (!lock_now)         low_cnt <= low_cnt + 1'b1;
    end

    // Purpose: sticky lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b0;
        else if (lock_now) locked <= 1'b1;
    end

    // Purpose: hold straps; load on lock, or follow them in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= '0;
            fsel_q <= 1'b0;
        end else if (lock_now || test_s) begin
            fs_q   <= fs_s;
            fsel_q <= fsel_s;
        end
    end
endmodule

// File: rtl/pgsl_decode.sv
// Module: decodes the held straps into frequency code, group enables,
// test-output control and the power-down request. Purely combinational.
module pgsl_decode
    import pgsl_pkg::*;
(
    input  logic            locked,
    input  logic            test_s,
    input  logic            pg_s,
    input  logic [FS_W-1:0] fs_q,
    input  logic            fsel_q,
    output freq_code_e      cpu_freq,
    output logic            strap_invalid,
    output logic            en_dot96,
    output logic            en_27m,
    output logic            pwr_down,
    output logic            test_tristate,
    output logic            test_refn
);
    logic valid_pat;
    logic run_ok;

    // Purpose: map the strap pattern to a code, falling back to 100 MHz.
    always_comb begin
        valid_pat = 1'b1;
        unique case (fs_q)
            PAT_100: cpu_freq = FREQ_100;
            PAT_133: cpu_freq = FREQ_133;
            PAT_166: cpu_freq = FREQ_166;
            PAT_200: cpu_freq = FREQ_200;
            default: begin
                cpu_freq  = FREQ_100;
                valid_pat = 1'b0;
            end
        endcase
    end

    // Purpose: flag a bad pattern only once straps are meaningful.
    assign strap_invalid = (locked || test_s) && !valid_pat;

    // Purpose: mutually exclusive output-group enables in normal running.
    assign run_ok   = locked && !test_s;
    assign en_dot96 = run_ok &&  fsel_q;
    assign en_27m   = run_ok && !fsel_q;

    // Purpose: pin reused as active-high power-down after lock.
    assign pwr_down = locked && pg_s;

    // Purpose: test-mode output behaviour selected by held strap B.
    assign test_tristate = test_s && !fs_q[1];
    assign test_refn     = test_s &&  fs_q[1];
endmodule

// File: rtl/pg_strap_latch.sv
// Module: top level of the power-good strap latch controller.
// Assumes clk runs before power-good is asserted and rst_n is synchronous.
module pg_strap_latch
    import pgsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VALID_CNT   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_pd_pin,
    input  logic       fs_a,
    input  logic       fs_b,
    input  logic       fs_c,
    input  logic       fsel,
    input  logic       test_mode,
    output logic       locked,
    output logic [2:0] fs_latched,
    output logic       fsel_latched,
    output logic [1:0] cpu_freq,
    output logic       strap_invalid,
    output logic       en_dot96,
    output logic       en_27m,
    output logic       pwr_down,
    output logic       test_tristate,
    output logic       test_refn
);
    localparam int PIN_W = FS_W + 3;
    // Pin bundle order: {pg, test, fsel, C, B, A}; pg resets high (inactive).
    localparam logic [PIN_W-1:0] PIN_RST = {1'b1, {(PIN_W-1){1'b0}}};

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic             pg_s;
    logic             test_q;
    logic             fsel_s;
    logic [FS_W-1:0]  fs_s;
    logic [FS_W-1:0]  fs_q;
    logic             fsel_q;
    freq_code_e       freq_e;

    assign pins_raw = {pg_pd_pin, test_mode, fsel, fs_c, fs_b, fs_a};
    assign {pg_s, test_q, fsel_s, fs_s} = pins_s;

    pgsl_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    pgsl_capture #(
        .VALID_CNT (VALID_CNT),
        .FS_W      (FS_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_s   (pg_s),
        .test_s (test_q),
        .fs_s   (fs_s),
        .fsel_s (fsel_s),
        .locked (locked),
        .fs_q   (fs_q),
        .fsel_q (fsel_q)
    );

    pgsl_decode u_dec (
        .locked        (locked),
        .test_s        (test_q),
        .pg_s          (pg_s),
        .fs_q          (fs_q),
        .fsel_q        (fsel_q),
        .cpu_freq      (freq_e),
        .strap_invalid (strap_invalid),
        .en_dot96      (en_dot96),
        .en_27m        (en_27m),
        .pwr_down      (pwr_down),
        .test_tristate (test_tristate),
        .test_refn     (test_refn)
    );

    assign fs_latched   = fs_q;
    assign fsel_latched = fsel_q;
    assign cpu_freq     = freq_e;
endmodule

// File: rtl/pgsl_checker.sv
// Module: temporal checks for pg_strap_latch, attached by bind.
module pgsl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       locked,
    input logic       test_q,
    input logic [2:0] fs_latched,
    input logic       fsel_latched,
    input logic [1:0] cpu_freq,
    input logic       strap_invalid,
    input logic       en_dot96,
    input logic       en_27m,
    input logic       pwr_down,
    input logic       test_tristate,
    input logic       test_refn
);
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && !$past(test_q)) |-> ($stable(fs_latched) && $stable(fsel_latched)));

    a_r6_pd_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> locked);

    a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        strap_invalid |-> (cpu_freq == 2'd0));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_dot96 && en_27m));

    a_r11_test_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({test_tristate, test_refn}) <= 1);
endmodule

bind pg_strap_latch pgsl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .locked        (locked),
    .test_q        (test_q),
    .fs_latched    (fs_latched),
    .fsel_latched  (fsel_latched),
    .cpu_freq      (cpu_freq),
    .strap_invalid (strap_invalid),
    .en_dot96      (en_dot96),
    .en_27m        (en_27m),
    .pwr_down      (pwr_down),
    .test_tristate (test_tristate),
    .test_refn     (test_refn)
);

// File: tb/sim_pg_strap_latch.sv
module sim_pg_strap_latch;
    localparam time CYC = 10ns;

    logic clk = 1'b0;
    logic rst_n, pg_pd_pin, fs_a, fs_b, fs_c, fsel, test_mode;
    logic locked, fsel_latched, strap_invalid, en_dot96, en_27m;
    logic pwr_down, test_tristate, test_refn;
    logic [2:0] fs_latched;
    logic [1:0] cpu_freq;

    int n_chk = 0;
    int n_err = 0;

    always #(CYC/2) clk = ~clk;

    pg_strap_latch u0 (.*);

    // Vector: {fs[2:0] as CBA, fsel, expected code[1:0], expected invalid}
    localparam logic [6:0] VEC [8] = '{
        7'b000_0_00_1, 7'b001_1_01_0, 7'b010_0_11_0, 7'b011_1_10_0,
        7'b100_0_00_1, 7'b101_1_00_0, 7'b110_0_00_1, 7'b111_1_00_1
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pg_pd_pin = 1'b1; test_mode = 1'b0;
        {fs_c, fs_b, fs_a} = 3'b000; fsel = 1'b0;
        edges(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CYC * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 locked", locked, 0);
        chk("R1 fs_latched", fs_latched, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 enables", {en_dot96, en_27m, test_tristate, test_refn}, 0);

        // Table walk: R3 capture, R7 decode, R8 fallback, R9 group select
        for (int i = 0; i < 8; i++) begin
            do_reset();
            {fs_c, fs_b, fs_a} = VEC[i][6:4];
            fsel = VEC[i][3];
            pg_pd_pin = 1'b0;
            edges(4);
            chk("R3 fs_latched", fs_latched, VEC[i][6:4]);
            chk("R3 fsel_latched", fsel_latched, VEC[i][3]);
            chk("R7 cpu_freq", cpu_freq, VEC[i][2:1]);
            chk("R8 strap_invalid", strap_invalid, VEC[i][0]);
            chk("R9 en_dot96", en_dot96, VEC[i][3]);
            chk("R9 en_27m", en_27m, !VEC[i][3]);
        end

        // R2 lock latency and glitch rejection
        do_reset();
        pg_pd_pin = 1'b0;
        @(negedge clk);
        pg_pd_pin = 1'b1;
        edges(6);
        chk("R2 glitch no lock", locked, 0);
        chk("R6 no pd before lock", pwr_down, 0);
        {fs_c, fs_b, fs_a} = 3'b101; fsel = 1'b1;
        pg_pd_pin = 1'b0;
        edges(3);
        chk("R2 not yet locked", locked, 0);
        edges(1);
        chk("R2 locked on 4th edge", locked, 1);

        // R6 power-down follows pin after lock, R5 lock sticks
        pg_pd_pin = 1'b1;
        edges(1);
        chk("R6 pd after 1 edge", pwr_down, 0);
        edges(1);
        chk("R6 pd after 2 edges", pwr_down, 1);
        chk("R5 lock kept with pin high", locked, 1);
        pg_pd_pin = 1'b0;
        edges(2);
        chk("R6 pd released", pwr_down, 0);

        // R4 straps ignored after lock
        {fs_c, fs_b, fs_a} = 3'b010; fsel = 1'b0;
        pg_pd_pin = 1'b1;
        edges(2);
        pg_pd_pin = 1'b0;
        edges(6);
        chk("R4 fs frozen", fs_latched, 3'b101);
        chk("R4 fsel frozen", fsel_latched, 1);
        chk("R4 code frozen", cpu_freq, 0);

        // R10 test mode transparency, R11 test output select
        do_reset();
        test_mode = 1'b1;
        {fs_c, fs_b, fs_a} = 3'b011;
        edges(2);
        chk("R10 not yet followed", fs_latched, 0);
        edges(1);
        chk("R10 followed unlocked", fs_latched, 3'b011);
        chk("R11 refn with FSB=1", test_refn, 1);
        chk("R11 no tristate", test_tristate, 0);
        chk("R9 no enables in test", {en_dot96, en_27m}, 0);
        pg_pd_pin = 1'b0;
        edges(5);
        chk("R10 locked in test", locked, 1);
        {fs_c, fs_b, fs_a} = 3'b100;
        edges(3);
        chk("R10 followed after lock", fs_latched, 3'b100);
        chk("R11 tristate with FSB=0", test_tristate, 1);
        chk("R8 invalid in test", strap_invalid, 1);
        test_mode = 1'b0;
        {fs_c, fs_b, fs_a} = 3'b001;
        edges(5);
        chk("R4 frozen after test exit", fs_latched, 3'b100);
        chk("R11 off outside test", {test_tristate, test_refn}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule